// File: doc/BRIEF.md
# Asynchronous External Memory Burst Controller

This block is a bus master for an asynchronous external memory or peripheral with a 32-bit data path. It turns a request on a simple internal handshake into a timed sequence of address, chip select, read strobe and write strobe. Each access has three phases: address setup, strobe, then hold. Every phase length comes from configuration inputs.

A request carries a length code. A length code of zero gives a single-word access, which uses the single-access setup, strobe and hold counts. Any other code gives a burst of 2, 4 or 8 words. In a burst, the first word pays the burst setup count and the last word pays the burst hold count. Every word of the burst, including the first and the last, gets a fixed strobe window of `BEAT_CLKS` clocks. The address advances by one word per beat. With two-clock burst setup and hold, an eight-word burst takes 20 bus clocks. Eight single accesses at the conservative 3/5/2 timing take 80 clocks.

The external bidirectional data bus is modelled as separate input and output buses plus an output enable. Read words come back with a one-cycle valid pulse. During a write burst, the requester supplies each following word when the controller signals that it is taking one. A one-cycle done pulse ends every access.

Top module: `amem_burst_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_cs_n`, `bus_oe_n` and `bus_we_n` are 1, and `bus_dout_en`, `rd_valid`, `done` and `wdata_take` are 0.
- R2: A single access (`req_len` = 0) runs in three phases, with `bus_cs_n` low in all of them. Setup lasts `cfg_setup` cycles with both strobes high. Strobe lasts `cfg_strobe` cycles with `bus_oe_n` low for a read or `bus_we_n` low for a write. Hold lasts `cfg_hold` cycles with both strobes high. `bus_oe_n` and `bus_we_n` are never low together.
- R3: `req_len` codes 1, 2 and 3 select bursts of 2, 4 and 8 words. A burst has `cfg_bsetup` setup cycles, then `BEAT_CLKS` (default 2) strobe cycles per word with the strobe held low, then `cfg_bhold` hold cycles. An 8-word burst with 2-cycle setup and hold takes 20 cycles from acceptance to the done cycle.
- R4: `bus_addr` equals `req_addr` during setup and the first beat. It increases by exactly one at each later beat, and it keeps the last beat's address during hold.
- R5: For a read, `rd_valid` pulses for one cycle right after the last strobe cycle of each beat. `rd_data` then holds the `bus_din` value present in that last strobe cycle.
- R6: For a write, the word on `wdata` at acceptance drives `bus_dout` for the first beat. `bus_dout_en` is 1 for as long as `bus_cs_n` is low, and it stays 0 for reads. `wdata_take` is 1 in the last strobe cycle of every beat except the final one. The word on `wdata` in that cycle drives the next beat.
- R7: `done` is a one-cycle pulse in the first cycle after the hold phase, and `req_ready` is 1 in that same cycle.
- R8: `req_ready` is 0 from the cycle after acceptance until the done cycle. `req_valid` and the request fields have no effect on the bus while `req_ready` is 0.
- R9: A configuration count of 0 behaves as 1. Configuration inputs are captured at acceptance, so changing them during an access does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Starting word address |
| req_len | input | 2 | Length code: 0 single, 1/2/3 = 2/4/8-word burst |
| wdata | input | DW | Write word (first word with request, later words on `wdata_take`) |
| wdata_take | output | 1 | The current `wdata` word is taken at the end of this cycle |
| rd_valid | output | 1 | One-cycle pulse for each read word |
| rd_data | output | DW | Read word |
| done | output | 1 | One-cycle end-of-access pulse |
| cfg_setup | input | CW | Single-access setup cycles |
| cfg_strobe | input | CW | Single-access strobe cycles |
| cfg_hold | input | CW | Single-access hold cycles |
| cfg_bsetup | input | CW | Burst setup cycles |
| cfg_bhold | input | CW | Burst hold cycles |
| bus_addr | output | AW | External word address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dout | output | DW | Outgoing data |
| bus_dout_en | output | 1 | Drive enable for outgoing data |
| bus_din | input | DW | Incoming data |

## Verification
The assertions rely on the external data coming only from `bus_din`. They also assume that `BEAT_CLKS` is at least 2, so that a take of write data never falls in two consecutive cycles. The bench keeps within these assumptions. It holds `req_valid` high throughout busy periods to show it is ignored, and drops it before each done cycle so that no request is accepted unplanned. It changes the configuration only after acceptance, and it updates `wdata` in the cycle after each observed take.

// File: rtl/amem_pkg.sv
package amem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Number of words selected by a length code (1, 2, 4 or 8).
    function automatic logic [3:0] words_of(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/amem_cfg_latch.sv
module amem_cfg_latch #(
    parameter int CW        = 4,
    parameter int BEAT_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          burst_in,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_bsetup,
    input  logic [CW-1:0] cfg_bhold,
    output logic [CW-1:0] setup_now,
    output logic [CW-1:0] strobe_q,
    output logic [CW-1:0] hold_q
);
    localparam logic [CW-1:0] BEAT_LEN = CW'(BEAT_CLKS);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0] strobe;
        logic [CW-1:0] hold;
    } timing_t;

    timing_t tm_d, tm_q;

    function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    always_comb begin
        tm_d      = tm_q;
        setup_now = burst_in ? at_least_one(cfg_bsetup) : at_least_one(cfg_setup);
        if (load) begin
            tm_d.strobe = burst_in ? BEAT_LEN : at_least_one(cfg_strobe);
            tm_d.hold   = burst_in ? at_least_one(cfg_bhold) : at_least_one(cfg_hold);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '{strobe: ONE, hold: ONE};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign strobe_q = tm_q.strobe;
    assign hold_q   = tm_q.hold;

endmodule

// File: rtl/amem_phase_timer.sv
module amem_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/amem_beat_ctr.sv
module amem_beat_ctr #(
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          advance,
    input  logic [AW-1:0] start_addr,
    input  logic [BW-1:0] start_words,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          last_beat
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [BW-1:0] left;
        logic [DW-1:0] data;
    } beat_t;

    beat_t bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        if (start) begin
            bt_d.addr = start_addr;
            bt_d.left = start_words - BW'(1);
            bt_d.data = wdata;
        end else if (advance) begin
            bt_d.addr = bt_q.addr + AW'(1);
            bt_d.left = bt_q.left - BW'(1);
            bt_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= '0;
        end else begin
            bt_q <= bt_d;
        end
    end

    assign addr      = bt_q.addr;
    assign dout      = bt_q.data;
    assign last_beat = (bt_q.left == '0);

endmodule

// File: rtl/amem_burst_ctrl.sv
module amem_burst_ctrl
    import amem_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 32,
    parameter int CW        = 4,
    parameter int BEAT_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_len,
    input  logic [DW-1:0] wdata,
    output logic          wdata_take,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_bsetup,
    input  logic [CW-1:0] cfg_bhold,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din
);
    localparam int BW = 4;

    typedef struct packed {
        phase_e        phase;
        logic          write;
        logic          cs_n;
        logic          oe_n;
        logic          we_n;
        logic          dout_en;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
        logic          done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          start;
    logic          advance;
    logic          t_load;
    logic [CW-1:0] t_len;
    logic          t_expired;
    logic [CW-1:0] setup_now, strobe_q, hold_q;
    logic          last_beat;

    amem_cfg_latch #(.CW(CW), .BEAT_CLKS(BEAT_CLKS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .burst_in  (req_len != 2'd0),
        .cfg_setup (cfg_setup),
        .cfg_strobe(cfg_strobe),
        .cfg_hold  (cfg_hold),
        .cfg_bsetup(cfg_bsetup),
        .cfg_bhold (cfg_bhold),
        .setup_now (setup_now),
        .strobe_q  (strobe_q),
        .hold_q    (hold_q)
    );

    amem_phase_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .len    (t_len),
        .expired(t_expired)
    );

    amem_beat_ctr #(.AW(AW), .DW(DW), .BW(BW)) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .advance    (advance),
        .start_addr (req_addr),
        .start_words(words_of(req_len)),
        .wdata      (wdata),
        .addr       (bus_addr),
        .dout       (bus_dout),
        .last_beat  (last_beat)
    );

    always_comb begin
        c_d          = c_q;
        c_d.rd_valid = 1'b0;
        c_d.done     = 1'b0;
        start        = 1'b0;
        advance      = 1'b0;
        t_load       = 1'b0;
        t_len        = setup_now;

        unique case (c_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    start     = 1'b1;
                    t_load    = 1'b1;
                    t_len     = setup_now;
                    c_d.write = req_write;
                    c_d.phase = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (t_expired) begin
                    t_load    = 1'b1;
                    t_len     = strobe_q;
                    c_d.phase = PH_STROBE;
                end
            end
            PH_STROBE: begin
                if (t_expired) begin
                    if (!c_q.write) begin
                        c_d.rd_valid = 1'b1;
                        c_d.rd_data  = bus_din;
                    end
                    t_load = 1'b1;
                    if (last_beat) begin
                        t_len     = hold_q;
                        c_d.phase = PH_HOLD;
                    end else begin
                        t_len   = strobe_q;
                        advance = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (t_expired) begin
                    c_d.done  = 1'b1;
                    c_d.phase = PH_IDLE;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase

        c_d.cs_n    = (c_d.phase == PH_IDLE);
        c_d.oe_n    = !((c_d.phase == PH_STROBE) && !c_d.write);
        c_d.we_n    = !((c_d.phase == PH_STROBE) && c_d.write);
        c_d.dout_en = (c_d.phase != PH_IDLE) && c_d.write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_IDLE, write: 1'b0, cs_n: 1'b1, oe_n: 1'b1,
                     we_n: 1'b1, dout_en: 1'b0, rd_valid: 1'b0,
                     rd_data: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready   = (c_q.phase == PH_IDLE);
    assign wdata_take  = advance && c_q.write;
    assign rd_valid    = c_q.rd_valid;
    assign rd_data     = c_q.rd_data;
    assign done        = c_q.done;
    assign bus_cs_n    = c_q.cs_n;
    assign bus_oe_n    = c_q.oe_n;
    assign bus_we_n    = c_q.we_n;
    assign bus_dout_en = c_q.dout_en;

endmodule

// File: rtl/amem_burst_chk.sv
module amem_burst_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          wdata_take,
    input logic          rd_valid,
    input logic          done,
    input logic [AW-1:0] bus_addr,
    input logic          bus_cs_n,
    input logic          bus_oe_n,
    input logic          bus_we_n,
    input logic          bus_dout_en
);
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n) && (bus_addr != $past(bus_addr)))
        |-> (bus_addr == $past(bus_addr) + AW'(1)));

    p_read_after_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(bus_oe_n));

    p_take_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_take |-> (!bus_we_n && bus_dout_en));

    p_take_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_take |=> !wdata_take);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && $past(!bus_cs_n)));

    p_busy_is_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == bus_cs_n);

endmodule

bind amem_burst_ctrl amem_burst_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .wdata_take (wdata_take),
    .rd_valid   (rd_valid),
    .done       (done),
    .bus_addr   (bus_addr),
    .bus_cs_n   (bus_cs_n),
    .bus_oe_n   (bus_oe_n),
    .bus_we_n   (bus_we_n),
    .bus_dout_en(bus_dout_en)
);

// File: tb/sim_amem_burst_ctrl.sv
`timescale 1ns/1ps
module sim_amem_burst_ctrl;
    localparam int AW = 20;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int BEAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_len = '0;
    logic [DW-1:0] wdata = '0;
    logic          wdata_take;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          done;
    logic [CW-1:0] cfg_setup = 4'd3, cfg_strobe = 4'd5, cfg_hold = 4'd2;
    logic [CW-1:0] cfg_bsetup = 4'd2, cfg_bhold = 4'd2;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    amem_burst_ctrl #(.AW(AW), .DW(DW), .CW(CW), .BEAT_CLKS(BEAT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .wdata(wdata), .wdata_take(wdata_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_bsetup(cfg_bsetup),
        .cfg_bhold(cfg_bhold), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int tag, input int j);
        return 32'hA500_0000 | 32'(tag << 8) | 32'(j);
    endfunction

    function automatic logic [31:0] din_of(input logic [AW-1:0] a);
        return 32'hD000_0000 | 32'(a);
    endfunction

    function automatic int lo1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Behavioural reference: the expected bus state is a function of the
    // cycle index k counted from acceptance.
    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [1:0] lc,
                        input int s, input int st, input int h, input int bs,
                        input int bh, input bit poke, input int tag);
        int n   = 1 << lc;
        bit bu  = (lc != 2'd0);
        int S   = bu ? lo1(bs) : lo1(s);
        int T   = bu ? BEAT : lo1(st);
        int H   = bu ? lo1(bh) : lo1(h);
        int tot = S + n * T + H;
        int widx = 1;
        bit prev_take = 1'b0;

        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before request", 32'(req_ready), 32'd1);
        cfg_setup = CW'(s); cfg_strobe = CW'(st); cfg_hold = CW'(h);
        cfg_bsetup = CW'(bs); cfg_bhold = CW'(bh);
        req_write = wr; req_addr = a; req_len = lc;
        wdata = word_of(tag, 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wdata = word_of(tag, 1);
        if (poke) begin
            // R9: configuration changed after acceptance; R8: request held while busy
            cfg_setup = 4'd9; cfg_strobe = 4'd9; cfg_hold = 4'd9;
            cfg_bsetup = 4'd9; cfg_bhold = 4'd9;
            req_addr = 20'hFFFF0; req_len = 2'd3; req_write = ~wr;
            req_valid = 1'b1;
        end
        for (int k = 0; k <= tot; k++) begin
            bit act, stb, exp_rdv, exp_take;
            int beat;
            if (k > 0) @(negedge clk);
            if (k == tot - 1) req_valid = 1'b0;
            if (prev_take) begin
                widx++;
                wdata = word_of(tag, widx);
            end
            act  = (k < tot);
            stb  = (k >= S) && (k < S + n * T);
            beat = (k < S) ? 0 : ((k < S + n * T) ? (k - S) / T : n - 1);
            exp_rdv  = !wr && (k - S >= T) && ((k - S) % T == 0) && (k - S <= n * T);
            exp_take = wr && stb && ((k - S) % T == T - 1) && (beat < n - 1);

            chk(bus_cs_n == !act, "R2 chip select", 32'(bus_cs_n), 32'(!act));
            chk(bus_oe_n == !(stb && !wr), "R2 R3 read strobe", 32'(bus_oe_n),
                32'(!(stb && !wr)));
            chk(bus_we_n == !(stb && wr), "R2 R3 write strobe", 32'(bus_we_n),
                32'(!(stb && wr)));
            chk(bus_dout_en == (act && wr), "R6 drive enable", 32'(bus_dout_en),
                32'(act && wr));
            chk(req_ready == !act, "R8 busy", 32'(req_ready), 32'(!act));
            chk(done == (k == tot), "R7 done pulse", 32'(done), 32'(k == tot));
            chk(rd_valid == exp_rdv, "R5 read valid", 32'(rd_valid), 32'(exp_rdv));
            chk(wdata_take == exp_take, "R6 write take", 32'(wdata_take), 32'(exp_take));
            if (act)
                chk(bus_addr == a + AW'(beat), "R4 address", 32'(bus_addr),
                    32'(a + AW'(beat)));
            if (act && wr)
                chk(bus_dout == word_of(tag, beat), "R6 write data", bus_dout,
                    word_of(tag, beat));
            if (exp_rdv)
                chk(rd_data == din_of(a + AW'((k - S) / T - 1)), "R5 read data",
                    rd_data, din_of(a + AW'((k - S) / T - 1)));
            prev_take = wdata_take;
            bus_din = din_of(bus_addr);
        end
        @(negedge clk);
        chk(bus_cs_n == 1'b1, "R8 no stray accept", 32'(bus_cs_n), 32'd1);
        chk(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(bus_cs_n && bus_oe_n && bus_we_n, "R1 strobes idle",
            {29'd0, bus_cs_n, bus_oe_n, bus_we_n}, 32'd7);
        chk(!bus_dout_en && !rd_valid && !done && !wdata_take, "R1 pulses idle",
            {28'd0, bus_dout_en, rd_valid, done, wdata_take}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after release", 32'(req_ready), 32'd1);

        xfer(1'b0, 20'h00100, 2'd0, 3, 5, 2, 2, 2, 1'b0, 1);  // R2 default single read
        xfer(1'b1, 20'h00200, 2'd0, 3, 5, 2, 2, 2, 1'b1, 2);  // R2 R9 single write, poked
        xfer(1'b0, 20'h00300, 2'd0, 1, 3, 1, 2, 2, 1'b0, 3);  // R2 minimum timing
        xfer(1'b0, 20'h00FF8, 2'd3, 3, 5, 2, 2, 2, 1'b0, 4);  // R3 8-word read, 20 clocks
        xfer(1'b1, 20'h01000, 2'd2, 3, 5, 2, 2, 2, 1'b1, 5);  // R3 R6 R8 4-word write
        xfer(1'b0, 20'h02000, 2'd1, 3, 5, 2, 1, 1, 1'b0, 6);  // R3 2-word read, 1/1
        xfer(1'b1, 20'hFFFF8, 2'd3, 3, 5, 2, 3, 1, 1'b0, 7);  // R4 R6 8-word write
        xfer(1'b1, 20'h03000, 2'd0, 0, 0, 0, 2, 2, 1'b0, 8);  // R9 zero counts
        xfer(1'b0, 20'h04000, 2'd2, 2, 2, 2, 0, 0, 1'b1, 9);  // R9 zero burst counts

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule